// File: doc/BRIEF.md
# Embedded Trigger Extraction Stage

This stage sits behind a variable-delay sample buffer in a multi-channel acquisition path. Upstream logic marks trigger events by setting the most significant bit of a channel's 16-bit sample lane. The buffer delays the stream, but the trigger marks are wanted as early as possible. The stage therefore takes two copies of the stream. The undelayed copy supplies the trigger marks. The delayed copy supplies the samples.

For each lane, the stage rebuilds the sample as a sign-extended 15-bit value: the marker bit is overwritten with the bit directly below it. The marker bits of all lanes in the undelayed word are ORed into one trigger output. All outputs are registered one clock after the input, and the output valid follows the input valid by that same clock.

The channel count and the total width are parameters. The total width must be exactly sixteen bits per channel, and elaboration stops with an error for any other setting.

Top module: `trig_extract`

## Requirements
- R1: Lane k (counting from 0) occupies bits [16k+15:16k] of both data words, and its trigger mark is bit 16k+15. No other bit of the trigger-source word can raise the trigger.
- R2: When `valid_in` is high at a rising edge, after that edge every lane of `data_out` equals the same lane of `data_in`, except that bit 15 of the lane is replaced by bit 14 of the lane.
- R3: The trigger is taken only from `trig_src`. Mark bits set in `data_in` never raise `trig_out`.
- R4: For a word accepted with `valid_in` high, `trig_out` after that edge is the OR of the mark bits of all lanes of `trig_src`.
- R5: `valid_out` equals `valid_in` as sampled at the previous rising edge. No output changes before that edge.
- R6: `trig_out` is high only in cycles where `valid_out` is high.
- R7: When `valid_in` is low at a rising edge, `data_out` keeps its value and `trig_out` is low after that edge, whatever the data inputs carry.
- R8: While `rst` is high at a rising edge, `valid_out`, `trig_out` and `data_out` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all inputs and outputs |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | DATA_W | Delayed sample word, taken from the buffer output |
| trig_src | input | DATA_W | Undelayed word carrying the trigger marks |
| valid_in | input | 1 | Qualifies both input words |
| data_out | output | DATA_W | Samples with the marks removed, sign-extended per lane |
| valid_out | output | 1 | Qualifies `data_out` and `trig_out` |
| trig_out | output | 1 | OR of all lane marks of the accepted word |

## Verification
The bench builds the stage with its defaults: four channels and a 64-bit word. Four lanes are enough to place a lone mark in the first lane, the last lane and the inner lanes, so an off-by-one in the mark position or a dropped lane in the OR shows up. The same width lets the bench set different marks in the delayed and undelayed words, which separates the two sources.

// File: rtl/trig_extract_pkg.sv
package trig_extract_pkg;

    // Width of one channel lane; the trigger mark is its top bit.
    localparam int LANE_W = 16;

    // Bit index of the mark for a lane counted from zero.
    function automatic int mark_pos(input int lane);
        return lane * LANE_W + (LANE_W - 1);
    endfunction

endpackage

// File: rtl/te_lane_clean.sv
// Rebuilds one lane: the mark position is refilled with the sample's
// sign bit so the lane reads as a sign-extended (LW-1)-bit value.
module te_lane_clean #(
    parameter int LW = 16
) (
    input  logic [LW-2:0] sample_bits,
    output logic [LW-1:0] clean
);

    always_comb begin
        clean = {sample_bits[LW-2], sample_bits};
    end

endmodule

// File: rtl/te_flag_or.sv
// Ripple OR of the per-lane marks.
module te_flag_or #(
    parameter int N = 4
) (
    input  logic [N-1:0] flags,
    output logic         any
);

    logic [N:0] acc;

    assign acc[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign acc[i+1] = acc[i] | flags[i];
    end

    assign any = acc[N];

endmodule

// File: rtl/trig_extract.sv
module trig_extract
    import trig_extract_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_in,
    input  logic [DATA_W-1:0] trig_src,
    input  logic              valid_in,
    output logic [DATA_W-1:0] data_out,
    output logic              valid_out,
    output logic              trig_out
);

    localparam int LW = LANE_W;

    if (DATA_W != NUM_CH * LW) begin : g_cfg_bad
        $error("trig_extract: DATA_W must be NUM_CH*16");
    end

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              trig;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] clean_w;
    logic [NUM_CH-1:0] mark_w;
    logic              any_mark;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
        te_lane_clean #(.LW(LW)) u_clean (
            .sample_bits (data_in[k*LW +: LW-1]),
            .clean       (clean_w[k*LW +: LW])
        );

        assign mark_w[k] = trig_src[mark_pos(k)];

        logic unused_lane;
        assign unused_lane = data_in[mark_pos(k)] ^ (^trig_src[k*LW +: LW-1]);
    end

    te_flag_or #(.N(NUM_CH)) u_or (
        .flags (mark_w),
        .any   (any_mark)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_in;
        st_d.trig  = 1'b0;
        if (valid_in) begin
            st_d.data = clean_w;
            st_d.trig = any_mark;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_out  = st_q.data;
    assign valid_out = st_q.valid;
    assign trig_out  = st_q.trig;

    // R6: a trigger is never reported without valid output data
    p_trig_gated_r6: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> valid_out);

    // R5: output valid follows input valid by one edge
    p_valid_follow_r5: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);

    p_valid_drop_r5: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);

    // R7: idle input leaves data untouched
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> $stable(data_out));

    // R3: no mark in the trigger source means no trigger
    p_quiet_src_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_in && trig_src == '0) |=> !trig_out);

    // R2: every registered lane is sign-extended
    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        p_lane_sext_r2: assert property (@(posedge clk) disable iff (rst)
            valid_out |-> (data_out[mark_pos(k)] == data_out[mark_pos(k)-1]));
    end

endmodule

// File: tb/trig_extract_tb.sv
module trig_extract_tb;

    localparam int NUM_CH = 4;
    localparam int DATA_W = 64;
    localparam int LW     = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic [DATA_W-1:0] data_in;
    logic [DATA_W-1:0] trig_src;
    logic              valid_in;
    logic [DATA_W-1:0] data_out;
    logic              valid_out;
    logic              trig_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    trig_extract #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .data_in   (data_in),
        .trig_src  (trig_src),
        .valid_in  (valid_in),
        .data_out  (data_out),
        .valid_out (valid_out),
        .trig_out  (trig_out)
    );

    function automatic logic [DATA_W-1:0] model_clean(input logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] r = w;
        for (int k = 0; k < NUM_CH; k++) r[k*LW+15] = w[k*LW+14];
        return r;
    endfunction

    function automatic logic model_trig(input logic [DATA_W-1:0] w);
        logic a = 1'b0;
        for (int k = 0; k < NUM_CH; k++) a |= w[k*LW+15];
        return a;
    endfunction

    function automatic logic [DATA_W-1:0] mark_mask();
        logic [DATA_W-1:0] m = '0;
        for (int k = 0; k < NUM_CH; k++) m[k*LW+15] = 1'b1;
        return m;
    endfunction

    task automatic chk(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns after the next rising edge.
    task automatic step(input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] t,
                        input logic v);
        @(negedge clk);
        data_in  = d;
        trig_src = t;
        valid_in = v;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step({NUM_CH{16'hC123}}, mark_mask(), 1'b1);
        step({NUM_CH{16'hC123}}, mark_mask(), 1'b1);
        chk("R8 valid_out", {63'd0, valid_out}, '0);
        chk("R8 trig_out", {63'd0, trig_out}, '0);
        chk("R8 data_out", data_out, '0);
        @(negedge clk);
        rst = 1'b0;
        valid_in = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic t_each_lane();
        for (int k = 0; k < NUM_CH; k++) begin
            logic [DATA_W-1:0] d = 64'h1234_A5A5_7E01_C3F0 ^ (64'h1111 << (k*LW));
            logic [DATA_W-1:0] t = '0;
            t[k*LW+15] = 1'b1;
            step(d, t, 1'b1);
            chk("R2 lane data", data_out, model_clean(d));
            chk("R1/R4 lone mark", {63'd0, trig_out}, 64'd1);
            chk("R5 valid_out", {63'd0, valid_out}, 64'd1);
        end
    endtask

    task automatic t_no_marks();
        // every non-mark bit of trig_src set, mark bits clear (R1)
        step(64'h0F0F_0F0F_0F0F_0F0F, ~mark_mask(), 1'b1);
        chk("R1 non-mark bits", {63'd0, trig_out}, 64'd0);
        // marks only in delayed data (R3)
        step(mark_mask() | 64'h0123_4567_89AB_CDEF, '0, 1'b1);
        chk("R3 data marks ignored", {63'd0, trig_out}, 64'd0);
        chk("R2 data with marks", data_out, model_clean(mark_mask() | 64'h0123_4567_89AB_CDEF));
    endtask

    task automatic t_multi();
        logic [DATA_W-1:0] t = mark_mask();
        step(64'hFFFF_0000_8000_7FFF, t, 1'b1);
        chk("R4 all marks", {63'd0, trig_out}, 64'd1);
        t = '0;
        t[15] = 1'b1;
        t[63] = 1'b1;
        step(64'h0, t, 1'b1);
        chk("R4 two marks", {63'd0, trig_out}, 64'd1);
    endtask

    task automatic t_sign();
        step(64'h7FFF_8000_4000_BFFF, '0, 1'b1);
        chk("R2 sign patterns", data_out, 64'hFFFF_0000_C000_3FFF);
    endtask

    task automatic t_hold();
        logic [DATA_W-1:0] d0 = 64'h2468_1357_0ACE_5BDF;
        logic [DATA_W-1:0] kept;
        step(d0, mark_mask(), 1'b1);
        kept = data_out;
        chk("R2 before hold", kept, model_clean(d0));
        step(64'hDEAD_BEEF_CAFE_F00D, mark_mask(), 1'b0);
        chk("R7 data held", data_out, kept);
        chk("R7 no trigger", {63'd0, trig_out}, 64'd0);
        chk("R6 valid low", {63'd0, valid_out}, 64'd0);
        step(64'h0, mark_mask(), 1'b0);
        chk("R7 data still held", data_out, kept);
    endtask

    task automatic t_latency();
        logic [DATA_W-1:0] prev = data_out;
        @(negedge clk);
        data_in  = 64'h1111_2222_3333_4444;
        trig_src = mark_mask();
        valid_in = 1'b1;
        #1;
        chk("R5 no early data", data_out, prev);
        chk("R5 no early valid", {63'd0, valid_out}, 64'd0);
        @(posedge clk);
        #1;
        chk("R5 data after edge", data_out, model_clean(64'h1111_2222_3333_4444));
        chk("R5 valid after edge", {63'd0, valid_out}, 64'd1);
    endtask

    task automatic t_stream();
        logic [DATA_W-1:0] d = 64'h0;
        for (int i = 0; i < 8; i++) begin
            logic [DATA_W-1:0] t = 64'h0;
            d = d * 64'd6364136223846793005 + 64'd1442695040888963407;
            if (i % 3 == 1) t[(i % NUM_CH)*LW+15] = 1'b1;
            t = t | (d & ~mark_mask());
            step(d, t, 1'b1);
            chk("R2 stream data", data_out, model_clean(d));
            chk("R4 stream trigger", {63'd0, trig_out}, {63'd0, model_trig(t)});
        end
    endtask

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        data_in  = '0;
        trig_src = '0;
        valid_in = 1'b0;
        rst      = 1'b1;
        t_reset();
        t_each_lane();
        t_no_marks();
        t_multi();
        t_sign();
        t_hold();
        t_latency();
        t_stream();
        finish_run();
    end

endmodule